// File: doc/BRIEF.md
# Rotate-and-Mask Bit-Field Unit

This block rotates a 32-bit source word left by a 5-bit amount, then gates the rotated word with a contiguous bit mask. The mask is described by a begin index and an end index. Index 0 names the most significant bit. When the end index is below the begin index, the mask wraps around the word. Three operations are provided:

- rotate by an immediate amount, then mask;
- rotate by the low bits of a register value, then mask;
- rotate by an immediate amount, then insert the masked bits into a previous destination value.

An execution pipeline drives the decoded instruction fields straight into the ports. When the record flag is set, the unit also produces a four-bit condition nibble for field 0. The nibble is derived from the sign of the result and from the caller's summary-overflow bit.

The datapath is purely combinational. The parameter `OUT_REG` selects whether a clock-enabled output register follows it. With the default `OUT_REG = 1`, the result appears one clock after it is presented with `en` high.

Top module: `rotm_unit`

## Requirements
- R1: While reset is asserted, and afterwards until the first rising edge with `en` high, `result`, `cr_field` and `cr_write` are all zero.
- R2: When `mask_begin <= mask_end`, the mask holds ones exactly at positions `mask_begin` through `mask_end` inclusive. Position p is vector bit 31-p.
- R3: When `mask_end < mask_begin`, the mask wraps. It holds ones at positions `mask_begin`..31 and at positions 0..`mask_end`, and zeros in between.
- R4: The source is rotated left by the shift amount with no bit lost. A shift of 0 passes the source through unchanged.
- R5: `variant` 2'b00 gives `result = rotl(src_word, sh_imm) & mask`. `variant` 2'b11 behaves identically to 2'b00.
- R6: `variant` 2'b01 uses only `sh_reg[4:0]` as the shift amount. The upper bits of `sh_reg` and the value of `sh_imm` have no effect.
- R7: `variant` 2'b10 (insert) gives `result = (dst_word & ~mask) | (rotl(src_word, sh_imm) & mask)`.
- R8: With `rec_flag` high, `cr_write` is 1 and `cr_field` is {negative, positive, zero, so_in} in bits 3..0. The sign test treats the result as signed. With `rec_flag` low, `cr_write` is 0 and `cr_field` is 4'b0000.
- R9: With `OUT_REG = 1`, all outputs take the new value at a rising edge where `en` is high. They hold their value at a rising edge where `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Clock enable for the output register |
| variant | input | 2 | 00 immediate-mask, 01 register-mask, 10 insert, 11 same as 00 |
| src_word | input | 32 | Word to rotate |
| dst_word | input | 32 | Previous destination value, used by insert |
| sh_imm | input | 5 | Shift amount from the instruction field |
| sh_reg | input | 32 | Register value; only bits 4:0 form the shift |
| mask_begin | input | 5 | First mask position, 0 = MSB |
| mask_end | input | 5 | Last mask position, 0 = MSB |
| rec_flag | input | 1 | Request a condition-field update |
| so_in | input | 1 | Summary-overflow bit copied into the nibble |
| result | output | 32 | Rotated and masked result |
| cr_field | output | 4 | {lt, gt, eq, so} condition nibble |
| cr_write | output | 1 | Condition nibble is valid for writing |

## Verification
Faults in this block show up in `result` one enabled cycle after the offending operand set is presented.

- A wrong mask bit or a wrong wrap decision changes the result word for a specific pair of begin and end indices.
- A broken rotator stage corrupts every shift amount that has that stage's bit set.

For this reason the immediate variant is checked against every combination of begin, end and shift. The insert variant is swept over all masks at several shifts, so that kept destination bits are distinguished from rotated source bits. A faulty sign test or a stray nibble appears in `cr_field` or `cr_write` on the same cycle as the result.

// File: rtl/rotm_pkg.sv
package rotm_pkg;
  typedef enum logic [1:0] {
    RM_IMM = 2'b00,
    RM_REG = 2'b01,
    RM_INS = 2'b10,
    RM_ALT = 2'b11
  } rm_variant_e;
endpackage

// File: rtl/rotm_mask_gen.sv
module rotm_mask_gen #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  mb,
  input  logic [IDX_W-1:0]  me,
  output logic [DATA_W-1:0] mask
);
  logic no_wrap;
  assign no_wrap = (mb <= me);

  // position p counts from the most significant bit
  for (genvar p = 0; p < DATA_W; p++) begin : g_pos
    localparam logic [IDX_W-1:0] POS = IDX_W'(p);
    logic inside_run;
    logic inside_wrap;
    assign inside_run  = (POS >= mb) && (POS <= me);
    assign inside_wrap = (POS >= mb) || (POS <= me);
    assign mask[DATA_W-1-p] = no_wrap ? inside_run : inside_wrap;
  end
endmodule

// File: rtl/rotm_rotl.sv
module rotm_rotl #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [IDX_W-1:0]  amt,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [0:IDX_W];
  assign stage[0] = din;

  for (genvar k = 0; k < IDX_W; k++) begin : g_stage
    localparam int STEP = 2 ** k;
    logic [DATA_W-1:0] turned;
    assign turned = {stage[k][DATA_W-1-STEP:0], stage[k][DATA_W-1:DATA_W-STEP]};
    assign stage[k+1] = amt[k] ? turned : stage[k];
  end

  assign dout = stage[IDX_W];
endmodule

// File: rtl/rotm_cr_gen.sv
module rotm_cr_gen #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic              so_in,
  input  logic              rec,
  output logic [3:0]        cr_fld,
  output logic              cr_wr
);
  logic is_neg;
  logic is_zero;
  logic is_pos;

  assign is_neg  = res[DATA_W-1];
  assign is_zero = (res == '0);
  assign is_pos  = !is_neg && !is_zero;

  always_comb begin
    cr_fld = 4'b0000;
    if (rec) begin
      cr_fld = {is_neg, is_pos, is_zero, so_in};
    end
  end

  assign cr_wr = rec;
endmodule

// File: rtl/rotm_unit.sv
module rotm_unit
  import rotm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        variant,
  input  logic [DATA_W-1:0] src_word,
  input  logic [DATA_W-1:0] dst_word,
  input  logic [IDX_W-1:0]  sh_imm,
  input  logic [DATA_W-1:0] sh_reg,
  input  logic [IDX_W-1:0]  mask_begin,
  input  logic [IDX_W-1:0]  mask_end,
  input  logic              rec_flag,
  input  logic              so_in,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        cr_field,
  output logic              cr_write
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync = rst_pipe[1];

  // operand selection
  rm_variant_e       var_e;
  logic [IDX_W-1:0]  sh_sel;
  logic              unused_shreg_hi;

  assign var_e           = rm_variant_e'(variant);
  assign sh_sel          = (var_e == RM_REG) ? sh_reg[IDX_W-1:0] : sh_imm;
  assign unused_shreg_hi = ^sh_reg[DATA_W-1:IDX_W];

  // datapath
  logic [DATA_W-1:0] rot_c;
  logic [DATA_W-1:0] mask_c;
  logic [DATA_W-1:0] res_c;
  logic [3:0]        cr_fld_c;
  logic              cr_wr_c;

  rotm_rotl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) rot_i (
    .din  (src_word),
    .amt  (sh_sel),
    .dout (rot_c)
  );

  rotm_mask_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) mask_i (
    .mb   (mask_begin),
    .me   (mask_end),
    .mask (mask_c)
  );

  always_comb begin
    if (var_e == RM_INS) begin
      res_c = (dst_word & ~mask_c) | (rot_c & mask_c);
    end else begin
      res_c = rot_c & mask_c;
    end
  end

  rotm_cr_gen #(.DATA_W(DATA_W)) cr_i (
    .res    (res_c),
    .so_in  (so_in),
    .rec    (rec_flag),
    .cr_fld (cr_fld_c),
    .cr_wr  (cr_wr_c)
  );

  AST_MASK_RUN_COUNT: assert property (@(posedge clk) disable iff (!rst_sync)
    (mask_begin <= mask_end) |-> ($countones(mask_c) == int'(mask_end) - int'(mask_begin) + 1)); // R2
  AST_MASK_WRAP_COUNT: assert property (@(posedge clk) disable iff (!rst_sync)
    (mask_end < mask_begin) |-> ($countones(mask_c) == DATA_W - (int'(mask_begin) - int'(mask_end) - 1))); // R3
  AST_ROT_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_sync)
    (sh_sel == '0) |-> (rot_c == src_word)); // R4
  AST_INSERT_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_sync)
    (var_e == RM_INS) |-> (((res_c ^ dst_word) & ~mask_c) == '0)); // R7
  AST_CR_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_sync)
    cr_wr_c |-> ($countones(cr_fld_c[3:1]) == 1)); // R8
  AST_CR_QUIET: assert property (@(posedge clk) disable iff (!rst_sync)
    !cr_wr_c |-> (cr_fld_c == 4'b0000)); // R8

  // output stage
  if (OUT_REG) begin : g_oreg
    logic [DATA_W-1:0] res_q, res_d;
    logic [3:0]        cr_q, cr_d;
    logic              wr_q, wr_d;

    always_comb begin
      res_d = res_q;
      cr_d  = cr_q;
      wr_d  = wr_q;
      if (en) begin
        res_d = res_c;
        cr_d  = cr_fld_c;
        wr_d  = cr_wr_c;
      end
    end

    always_ff @(posedge clk or negedge rst_sync) begin
      if (!rst_sync) begin
        res_q <= '0;
        cr_q  <= 4'b0000;
        wr_q  <= 1'b0;
      end else begin
        res_q <= res_d;
        cr_q  <= cr_d;
        wr_q  <= wr_d;
      end
    end

    assign result   = res_q;
    assign cr_field = cr_q;
    assign cr_write = wr_q;

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_sync)
      !en |=> ($stable(res_q) && $stable(cr_q) && $stable(wr_q))); // R9
  end else begin : g_comb
    assign result   = res_c;
    assign cr_field = cr_fld_c;
    assign cr_write = cr_wr_c;
  end
endmodule

// File: tb/rotm_unit_tb.sv
module rotm_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [1:0]  variant;
  logic [31:0] src_word;
  logic [31:0] dst_word;
  logic [4:0]  sh_imm;
  logic [31:0] sh_reg;
  logic [4:0]  mask_begin;
  logic [4:0]  mask_end;
  logic        rec_flag;
  logic        so_in;
  logic [31:0] result;
  logic [3:0]  cr_field;
  logic        cr_write;

  int total = 0;
  int bad   = 0;

  rotm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .variant(variant),
    .src_word(src_word), .dst_word(dst_word), .sh_imm(sh_imm), .sh_reg(sh_reg),
    .mask_begin(mask_begin), .mask_end(mask_end), .rec_flag(rec_flag), .so_in(so_in),
    .result(result), .cr_field(cr_field), .cr_write(cr_write)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] ref_mask(int mb, int me);
    logic [31:0] from_mb;
    logic [31:0] to_me;
    from_mb = 32'hFFFF_FFFF >> mb;
    to_me   = 32'hFFFF_FFFF << (31 - me);
    return (mb <= me) ? (from_mb & to_me) : (from_mb | to_me);
  endfunction

  function automatic logic [31:0] ref_rot(logic [31:0] x, int sh);
    if (sh == 0) return x;
    return (x << sh) | (x >> (32 - sh));
  endfunction

  function automatic logic [3:0] ref_cr(logic [31:0] r, logic so, logic rec);
    if (!rec) return 4'b0000;
    if (r == 32'h0) return {3'b001, so};
    if (r[31]) return {3'b100, so};
    return {3'b010, so};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] v, logic [31:0] s, logic [31:0] d, int shi,
                       logic [31:0] shr, int mb, int me, logic rec, logic so);
    variant    = v;
    src_word   = s;
    dst_word   = d;
    sh_imm     = 5'(shi);
    sh_reg     = shr;
    mask_begin = 5'(mb);
    mask_end   = 5'(me);
    rec_flag   = rec;
    so_in      = so;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 result in reset", result, 32'h0);
    chk("R1 cr_field in reset", {28'h0, cr_field}, 32'h0);
    chk("R1 cr_write in reset", {31'h0, cr_write}, 32'h0);
    rst_n = 1'b1;
    drive(2'b00, 32'hFFFF_FFFF, 32'h0, 0, 32'h0, 0, 31, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R1 result before first enable", result, 32'h0);
    chk("R1 cr_write before first enable", {31'h0, cr_write}, 32'h0);
  endtask

  // every begin, end and shift for the immediate variant (R2 R3 R4 R5)
  task automatic t_sweep_imm();
    logic [31:0] s;
    s = 32'h8E21_4B7D;
    en = 1'b1;
    for (int mb = 0; mb < 32; mb++) begin
      for (int me = 0; me < 32; me++) begin
        for (int sh = 0; sh < 32; sh++) begin
          drive(2'b00, s, 32'h0, sh, 32'h0, mb, me, 1'b0, 1'b0);
          @(negedge clk);
          chk((mb <= me) ? "R2 R4 R5 imm sweep" : "R3 R4 R5 imm sweep wrap",
              result, ref_rot(s, sh) & ref_mask(mb, me));
        end
      end
    end
  endtask

  task automatic t_reg_shift();
    en = 1'b1;
    drive(2'b01, 32'h1234_5678, 32'h0, 3, 32'hFFFF_FFE8, 0, 31, 1'b0, 1'b0);
    @(negedge clk);
    chk("R6 reg shift low bits only", result, 32'h3456_7812);
    drive(2'b01, 32'hC000_0001, 32'h0, 17, 32'h8000_0020, 0, 31, 1'b0, 1'b0);
    @(negedge clk);
    chk("R6 reg shift upper bits ignored", result, 32'hC000_0001);
    for (int sh = 0; sh < 32; sh++) begin
      drive(2'b01, 32'h0F1E_2D3C, 32'h0, 31 - sh, {27'h5A5A5A5, 5'(sh)}, 4, 27, 1'b0, 1'b0);
      @(negedge clk);
      chk("R6 reg shift sweep", result, ref_rot(32'h0F1E_2D3C, sh) & ref_mask(4, 27));
    end
  endtask

  task automatic t_alt_variant();
    en = 1'b1;
    drive(2'b11, 32'h1234_5678, 32'hFFFF_FFFF, 4, 32'h0, 4, 27, 1'b0, 1'b0);
    @(negedge clk);
    chk("R5 variant 11 as immediate", result, ref_rot(32'h1234_5678, 4) & ref_mask(4, 27));
    drive(2'b11, 32'h1234_5678, 32'hFFFF_FFFF, 9, 32'h0, 28, 3, 1'b0, 1'b0);
    @(negedge clk);
    chk("R5 variant 11 wrap", result, ref_rot(32'h1234_5678, 9) & ref_mask(28, 3));
  endtask

  task automatic t_insert();
    logic [31:0] s;
    logic [31:0] d;
    logic [31:0] m;
    int shs [4] = '{0, 1, 13, 31};
    s = 32'hA5C3_0F96;
    d = 32'h3C5A_F00F;
    en = 1'b1;
    foreach (shs[i]) begin
      for (int mb = 0; mb < 32; mb++) begin
        for (int me = 0; me < 32; me++) begin
          drive(2'b10, s, d, shs[i], 32'h0, mb, me, 1'b0, 1'b0);
          @(negedge clk);
          m = ref_mask(mb, me);
          chk("R7 insert", result, (d & ~m) | (ref_rot(s, shs[i]) & m));
        end
      end
    end
  endtask

  task automatic t_record();
    en = 1'b1;
    drive(2'b00, 32'h8000_0000, 32'h0, 0, 32'h0, 0, 31, 1'b1, 1'b1);
    @(negedge clk);
    chk("R8 negative nibble", {28'h0, cr_field}, {28'h0, ref_cr(32'h8000_0000, 1'b1, 1'b1)});
    chk("R8 write flag", {31'h0, cr_write}, 32'h1);
    drive(2'b00, 32'h0000_0005, 32'h0, 0, 32'h0, 0, 31, 1'b1, 1'b0);
    @(negedge clk);
    chk("R8 positive nibble", {28'h0, cr_field}, 32'h4);
    drive(2'b00, 32'hFFFF_0000, 32'h0, 0, 32'h0, 16, 31, 1'b1, 1'b1);
    @(negedge clk);
    chk("R8 zero nibble", {28'h0, cr_field}, 32'h3);
    drive(2'b10, 32'h0000_0001, 32'h7FFF_FFFF, 31, 32'h0, 0, 0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R8 insert sign", {28'h0, cr_field}, 32'h8);
    drive(2'b00, 32'h8000_0000, 32'h0, 0, 32'h0, 0, 31, 1'b0, 1'b1);
    @(negedge clk);
    chk("R8 no record nibble", {28'h0, cr_field}, 32'h0);
    chk("R8 no record flag", {31'h0, cr_write}, 32'h0);
  endtask

  task automatic t_hold();
    en = 1'b1;
    drive(2'b00, 32'hDEAD_BEEF, 32'h0, 0, 32'h0, 0, 31, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9 load", result, 32'hDEAD_BEEF);
    en = 1'b0;
    drive(2'b00, 32'h0000_0000, 32'h0, 0, 32'h0, 0, 31, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk("R9 hold result", result, 32'hDEAD_BEEF);
    chk("R9 hold nibble", {28'h0, cr_field}, 32'h8);
    chk("R9 hold flag", {31'h0, cr_write}, 32'h1);
    en = 1'b1;
    @(negedge clk);
    chk("R9 reload", result, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    drive(2'b00, 32'h0, 32'h0, 0, 32'h0, 0, 0, 1'b0, 1'b0);
    t_reset();
    t_sweep_imm();
    t_reg_shift();
    t_alt_variant();
    t_insert();
    t_record();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule